// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block holds the 8-bit processor status register of a small accumulator-based CPU and decides, for every executed operation, which of its flags change and to what. The execution stage hands it a class code for the operation, the two operands, the ALU result, an operand-width select, the bit moved out by a shift and the status bit of a multiply or divide. From these the unit works out carry, overflow, zero, negative and half-carry. Only the flags that the operation's class permits are written. All other flags keep their value.

The register also has a whole-register load path. The stacking logic uses it when it pulls the status byte back on return from interrupt. The two interrupt mask bits and the stop-disable bit change only through this load or through reset, and the load can never set the non-maskable interrupt mask. The unit stores no ALU result. A compare therefore differs from a subtract only in what the datapath around the unit does with the difference.

Top module: `ccr_unit`

## Requirements
- R1: Bit order from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C. After reset the register reads 8'hD0: S, X and I are set and all other bits are clear.
- R2: When `opValid` is low, or when `opClass` is 0 (push, pull, transfer, exchange, add-B-to-index), no bit of the register changes.
- R3: Class 1 (load/store) sets N to the result MSB and Z to result-is-zero, and clears V. C and H are held.
- R4: Class 2 (add) writes N, Z, V and C from the result at the selected width, with C the unsigned carry out and V set when like-signed operands give a result of the other sign. H is written with the carry out of bit 3 only when `opWide` is 0, and is held otherwise.
- R5: Class 3 (subtract) writes N, Z, V and C, with C set when unsigned A < B and V set when unlike-signed operands give a result whose sign differs from A. H is held.
- R6: Class 4 (compare) changes the flags exactly as class 3 does for the same operands and result.
- R7: Class 5 (index increment/decrement) writes only Z. Z is set when all 16 result bits are zero, whatever `opWide` is.
- R8: Class 6 (shift/rotate) loads `shiftBit` into C, sets N and Z from the result, and sets V to the new N XOR the new C. H is held.
- R9: Class 7 (multiply/divide) loads `statusBit` into C and sets Z from the result. All other flags are held.
- R10: When `opWide` is 0, only result bits 7:0 and operand bits 7 and 3 matter. Bit 7 is the MSB and the upper result byte is ignored. When `opWide` is 1, bit 15 is the MSB.
- R11: A whole load (`loadEn`) writes all eight bits from `loadData`, except that X becomes `loadData[6]` AND the old X. A load can clear X but never set it.
- R12: When `loadEn` and `opValid` are both high in the same cycle, the load wins and the operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation completes this cycle |
| opClass | input | 3 | Instruction class code (0..7) |
| opWide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| opRes | input | 16 | ALU result |
| shiftBit | input | 1 | Bit moved out by a shift or rotate |
| statusBit | input | 1 | Multiply/divide status bit |
| loadEn | input | 1 | Whole-register load strobe |
| loadData | input | 8 | Byte to load |
| ccr | output | 8 | Current register value |

## Verification
The whole-register load and a flag-updating operation can fall in the same cycle. This happens when the stacking logic restores the status byte while the execution stage retires an operation. The bench provokes it by raising `loadEn` together with an add, a shift and an index operation whose flag effects would differ from the loaded byte. It judges the outcome against the loaded value, with the X rule applied and no trace of the operation. Separate runs also load bytes with X set while X is already clear, to check that a load never raises X.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DATA_W = 16;
  localparam int CCR_W  = 8;

  localparam int BIT_S = 7;
  localparam int BIT_X = 6;
  localparam int BIT_H = 5;
  localparam int BIT_I = 4;
  localparam int BIT_N = 3;
  localparam int BIT_Z = 2;
  localparam int BIT_V = 1;
  localparam int BIT_C = 0;

  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_LDST   = 3'd1,
    OP_ADD    = 3'd2,
    OP_SUB    = 3'd3,
    OP_CMP    = 3'd4,
    OP_IDX    = 3'd5,
    OP_SHIFT  = 3'd6,
    OP_MULDIV = 3'd7
  } opClass_e;

  typedef enum logic [1:0] {C_ADD, C_SUB, C_SHIFT, C_STAT} cSrc_e;
  typedef enum logic [1:0] {V_CLR, V_ADD, V_SUB, V_NXC}    vSrc_e;

  typedef struct packed {
    logic  loadAll;
    logic  wrH;
    logic  wrN;
    logic  wrZ;
    logic  wrV;
    logic  wrC;
    logic  wideSel;
    cSrc_e cSrc;
    vSrc_e vSrc;
  } strobe_t;
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opClass,
  input  logic       opWide,
  input  logic       loadEn,
  output strobe_t    strb
);
  always_comb begin
    strb         = '0;
    strb.cSrc    = C_ADD;
    strb.vSrc    = V_CLR;
    strb.wideSel = opWide;
    if (loadEn) begin
      strb.loadAll = 1'b1;
    end else if (opValid) begin
      unique case (opClass_e'(opClass))
        OP_NONE: ;
        OP_LDST: begin
          strb.wrN = 1'b1; strb.wrZ = 1'b1; strb.wrV = 1'b1;
          strb.vSrc = V_CLR;
        end
        OP_ADD: begin
          strb.wrN = 1'b1; strb.wrZ = 1'b1; strb.wrV = 1'b1; strb.wrC = 1'b1;
          strb.wrH = ~opWide;
          strb.cSrc = C_ADD; strb.vSrc = V_ADD;
        end
        OP_SUB, OP_CMP: begin
          strb.wrN = 1'b1; strb.wrZ = 1'b1; strb.wrV = 1'b1; strb.wrC = 1'b1;
          strb.cSrc = C_SUB; strb.vSrc = V_SUB;
        end
        OP_IDX: begin
          strb.wrZ = 1'b1;
          strb.wideSel = 1'b1;
        end
        OP_SHIFT: begin
          strb.wrN = 1'b1; strb.wrZ = 1'b1; strb.wrV = 1'b1; strb.wrC = 1'b1;
          strb.cSrc = C_SHIFT; strb.vSrc = V_NXC;
        end
        OP_MULDIV: begin
          strb.wrZ = 1'b1; strb.wrC = 1'b1;
          strb.cSrc = C_STAT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ccr_dp.sv
module ccr_dp
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opRes,
  input  logic              shiftBit,
  input  logic              statusBit,
  input  logic [CCR_W-1:0]  loadData,
  output logic [CCR_W-1:0]  ccr
);
  localparam int NARROW_W = DATA_W / 2;

  logic aMsb, bMsb, rMsb, resZero;
  logic addCarry, subBorrow, halfCarry;
  logic newC, newV;
  logic [CCR_W-1:0] ccrNext;
  logic unusedOps;

  assign unusedOps = ^{opA, opB};

  assign aMsb = strb.wideSel ? opA[DATA_W-1]  : opA[NARROW_W-1];
  assign bMsb = strb.wideSel ? opB[DATA_W-1]  : opB[NARROW_W-1];
  assign rMsb = strb.wideSel ? opRes[DATA_W-1] : opRes[NARROW_W-1];
  assign resZero = strb.wideSel ? (opRes == '0) : (opRes[NARROW_W-1:0] == '0);

  assign addCarry  = (aMsb & bMsb) | (aMsb & ~rMsb) | (bMsb & ~rMsb);
  assign subBorrow = (~aMsb & bMsb) | (~aMsb & rMsb) | (bMsb & rMsb);
  assign halfCarry = (opA[3] & opB[3]) | (opA[3] & ~opRes[3]) | (opB[3] & ~opRes[3]);

  always_comb begin
    unique case (strb.cSrc)
      C_ADD:   newC = addCarry;
      C_SUB:   newC = subBorrow;
      C_SHIFT: newC = shiftBit;
      default: newC = statusBit;
    endcase
    unique case (strb.vSrc)
      V_ADD:   newV = (aMsb == bMsb) && (rMsb != aMsb);
      V_SUB:   newV = (aMsb != bMsb) && (rMsb != aMsb);
      V_NXC:   newV = rMsb ^ newC;
      default: newV = 1'b0;
    endcase
  end

  always_comb begin
    ccrNext = ccr;
    if (strb.loadAll) begin
      ccrNext        = loadData;
      ccrNext[BIT_X] = loadData[BIT_X] & ccr[BIT_X];
    end else begin
      if (strb.wrH) ccrNext[BIT_H] = halfCarry;
      if (strb.wrN) ccrNext[BIT_N] = rMsb;
      if (strb.wrZ) ccrNext[BIT_Z] = resZero;
      if (strb.wrV) ccrNext[BIT_V] = newV;
      if (strb.wrC) ccrNext[BIT_C] = newC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ccr <= CCR_RESET;
    else       ccr <= ccrNext;
  end

  // R11
  x_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ccr[BIT_X] |=> !ccr[BIT_X]);

  // R2
  masks_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadAll |=> $stable({ccr[BIT_S], ccr[BIT_X], ccr[BIT_I]}));
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opClass,
  input  logic        opWide,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [15:0] opRes,
  input  logic        shiftBit,
  input  logic        statusBit,
  input  logic        loadEn,
  input  logic [7:0]  loadData,
  output logic [7:0]  ccr
);
  strobe_t strb;

  ccr_ctrl u_ctrl (
    .opValid (opValid),
    .opClass (opClass),
    .opWide  (opWide),
    .loadEn  (loadEn),
    .strb    (strb)
  );

  ccr_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .opRes     (opRes),
    .shiftBit  (shiftBit),
    .statusBit (statusBit),
    .loadData  (loadData),
    .ccr       (ccr)
  );

  // R2
  none_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && (!opValid || opClass == 3'd0)) |=> $stable(ccr));

  // R7
  idx_only_z_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && opValid && opClass == 3'd5) |=> ($stable(ccr[7:3]) && $stable(ccr[1:0])));

  // R3
  ldst_clr_v_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && opValid && opClass == 3'd1) |=> (!ccr[1] && $stable(ccr[0]) && $stable(ccr[5])));

  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (ccr[5:0] == $past(loadData[5:0]) && ccr[7] == $past(loadData[7])));

  // R9
  muldiv_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && opValid && opClass == 3'd7) |=> (ccr[0] == $past(statusBit)));
endmodule

// File: tb/ccr_unit_tb.sv
`timescale 1ns/1ps
module ccr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, opWide, shiftBit, statusBit, loadEn;
  logic [2:0]  opClass;
  logic [15:0] opA, opB, opRes;
  logic [7:0]  loadData;
  logic [7:0]  ccr;

  int checks = 0;
  int errors = 0;
  logic [7:0] expCcr;
  bit done = 0;

  always #4 clk = ~clk;

  ccr_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass), .opWide(opWide),
    .opA(opA), .opB(opB), .opRes(opRes), .shiftBit(shiftBit), .statusBit(statusBit),
    .loadEn(loadEn), .loadData(loadData), .ccr(ccr)
  );

  function automatic logic [7:0] refModel(input logic [7:0] cur, input int cls,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
      input logic wide, input logic sb, input logic st);
    logic [7:0] n;
    int wbits, ua, ub, sa, sbv, lo, hi;
    logic msb, zero;
    n = cur;
    wbits = (wide || cls == 5) ? 16 : 8;
    ua = (wbits == 16) ? int'(a) : int'(a[7:0]);
    ub = (wbits == 16) ? int'(b) : int'(b[7:0]);
    sa  = (ua >= (1 << (wbits-1))) ? ua - (1 << wbits) : ua;
    sbv = (ub >= (1 << (wbits-1))) ? ub - (1 << wbits) : ub;
    lo = -(1 << (wbits-1)); hi = (1 << (wbits-1)) - 1;
    msb  = (wbits == 16) ? r[15] : r[7];
    zero = (wbits == 16) ? (r == 16'h0) : (r[7:0] == 8'h0);
    case (cls)
      1: begin n[3] = msb; n[2] = zero; n[1] = 1'b0; end
      2: begin
        n[3] = msb; n[2] = zero;
        n[0] = (ua + ub) >= (1 << wbits);
        n[1] = (sa + sbv) < lo || (sa + sbv) > hi;
        if (!wide) n[5] = (int'(a[3:0]) + int'(b[3:0])) > 15;
      end
      3, 4: begin
        n[3] = msb; n[2] = zero;
        n[0] = ua < ub;
        n[1] = (sa - sbv) < lo || (sa - sbv) > hi;
      end
      5: n[2] = (r == 16'h0);
      6: begin n[3] = msb; n[2] = zero; n[0] = sb; n[1] = msb ^ sb; end
      7: begin n[0] = st; n[2] = zero; end
      default: ;
    endcase
    return n;
  endfunction

  task automatic step(input int cls, input logic [15:0] a, input logic [15:0] b,
      input logic [15:0] r, input logic wide, input logic sb, input logic st,
      input logic valid, input logic ld, input logic [7:0] ldd, input string req);
    logic [7:0] e;
    @(negedge clk);
    opClass = cls[2:0]; opA = a; opB = b; opRes = r; opWide = wide;
    shiftBit = sb; statusBit = st; opValid = valid; loadEn = ld; loadData = ldd;
    if (ld) e = {ldd[7], ldd[6] & expCcr[6], ldd[5:0]};
    else if (valid) e = refModel(expCcr, cls, a, b, r, wide, sb, st);
    else e = expCcr;
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
    checks++;
    if (ccr !== e) begin
      errors++;
      $display("FAIL %s class=%0d a=%h b=%h r=%h w=%b: actual %h expected %h",
               req, cls, a, b, r, wide, ccr, e);
    end
    expCcr = e;
  endtask

  function automatic logic [15:0] rnd16();
    return 16'($urandom);
  endfunction

  function automatic logic [15:0] mask(input logic [15:0] v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic t_reset();
    rstN = 1'b0; opValid = 0; loadEn = 0; opClass = 0; opA = 0; opB = 0; opRes = 0;
    opWide = 0; shiftBit = 0; statusBit = 0; loadData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    checks++;
    if (ccr !== 8'hD0) begin
      errors++; $display("FAIL R1 reset: actual %h expected d0", ccr);
    end
    expCcr = 8'hD0;
  endtask

  task automatic t_none();
    for (int i = 0; i < 20; i++) begin
      step(0, rnd16(), rnd16(), 16'h0, 1'($urandom), 1, 1, 1, 0, 0, "R2 no-flag class");
      step(2, 16'h0, 16'h0, 16'h0, 0, 1, 1, 0, 0, 0, "R2 invalid op");
    end
  endtask

  task automatic t_ldst();
    step(1, 0, 0, 16'h0080, 0, 0, 0, 1, 0, 0, "R3 negative byte");
    step(1, 0, 0, 16'hAB00, 0, 0, 0, 1, 0, 0, "R3 R10 upper byte ignored");
    step(1, 0, 0, 16'h8000, 1, 0, 0, 1, 0, 0, "R3 wide negative");
    for (int i = 0; i < 30; i++)
      step(1, 0, 0, rnd16(), 1'($urandom), 0, 0, 1, 0, 0, "R3 random");
  endtask

  task automatic t_arith(input int cls, input string req);
    logic [15:0] a, b, r;
    logic w;
    for (int i = 0; i < 60; i++) begin
      w = 1'($urandom);
      a = rnd16(); b = rnd16();
      if (i == 0) begin a = 16'h007F; b = 16'h0001; w = 0; end
      if (i == 1) begin a = 16'h00FF; b = 16'h0001; w = 0; end
      if (i == 2) begin a = 16'h8000; b = 16'h8000; w = 1; end
      if (i == 3) begin a = 16'h0080; b = 16'h0001; w = 0; end
      if (i == 4) begin a = 16'h0005; b = 16'h0005; w = 0; end
      r = (cls == 2) ? a + b : a - b;
      if (!w) r = {8'($urandom), r[7:0]};
      step(cls, w ? a : {8'($urandom), a[7:0]}, w ? b : {8'($urandom), b[7:0]}, r, w, 0, 0, 1, 0, 0, req);
    end
  endtask

  task automatic t_idx();
    step(5, 0, 0, 16'h0000, 0, 0, 0, 1, 0, 0, "R7 zero");
    step(5, 0, 0, 16'h0100, 0, 0, 0, 1, 0, 0, "R7 upper byte counts");
    for (int i = 0; i < 20; i++)
      step(5, rnd16(), rnd16(), (i % 4 == 0) ? 16'h0 : rnd16(), 1'($urandom), 1'($urandom), 1'($urandom), 1, 0, 0, "R7 random");
  endtask

  task automatic t_shift();
    for (int i = 0; i < 30; i++)
      step(6, 0, 0, mask(rnd16(), 1'(i % 2)), 1'(i % 2), 1'($urandom), 0, 1, 0, 0, "R8 shift");
  endtask

  task automatic t_muldiv();
    for (int i = 0; i < 20; i++)
      step(7, rnd16(), rnd16(), (i % 3 == 0) ? 16'h0 : rnd16(), 1'($urandom), 0, 1'($urandom), 1, 0, 0, "R9 mul/div");
  endtask

  task automatic t_load();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h2F, "R11 load clears X");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, "R11 load cannot set X");
    for (int i = 0; i < 20; i++)
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'($urandom), "R11 random load");
  endtask

  task automatic t_collide();
    step(2, 16'h00FF, 16'h0001, 16'h0000, 0, 0, 0, 1, 1, 8'hC5, "R12 load vs add");
    step(6, 0, 0, 16'h0080, 0, 1, 0, 1, 1, 8'h00, "R12 load vs shift");
    step(5, 0, 0, 16'h0000, 1, 0, 0, 1, 1, 8'hBB, "R12 load vs index");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_none();
    t_ldst();
    t_arith(2, "R4 R10 add");
    t_arith(3, "R5 subtract");
    t_arith(4, "R6 compare");
    t_idx();
    t_shift();
    t_muldiv();
    t_load();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule